// File: doc/BRIEF.md
# Soft-Ramped Channel Volume Attenuator

This block scales one channel of signed 24-bit audio samples by a programmable attenuation. The attenuation setting is a code on a 0.5 dB scale with 182 levels, from 0 dB (code 0) down to 90.5 dB below full scale (code 181). When the setting changes, the gain does not jump. An internal attenuation register, counted in 0.125 dB units, walks toward the new target one unit at a time. The walk advances only on sample boundaries, and its pace is chosen by a two-bit rate field. Level changes therefore reach the output as smooth, click-free ramps.

A mute request uses the same ramp. The channel glides down to full attenuation, and the output is then forced to exact zero. A registered flag reports that the channel has reached silence, so it can drive an external muting circuit. When the mute request is released, the channel ramps back up to the programmed level.

Samples are presented with a one-clock strobe. The scaled sample appears on the next clock together with a one-clock valid pulse. The gain comes from a 48-entry table of 18-bit fractions covering one 6 dB span, and a right shift per completed span extends it over the full range. The product is rounded and saturated back to 24 bits.

Top module: `softVolume`

## Requirements
- R1: During and after reset, and before any sample strobe, `sampleOut` is 0 and `outValid` and `muteDone` are low. The internal attenuation starts at 724, which is full attenuation, and the sample-strobe counter starts at 0.
- R2: A `targetCode` value c in 0..181 selects a target attenuation of 4·c eighth-dB units. Any code above 181 acts as code 181, which gives a target of 724. The attenuation never leaves the range 0..724.
- R3: A strobe on `sampleValid` with sample s produces, one clock later, a one-clock `outValid` pulse and `sampleOut` = sat24((s·G + 2^(k-1)) >> k), where k = 17 + floor(n/48) and G = round(131072·10^(-(n mod 48)/160)). Here n is the attenuation in force before that strobe's update, and the shift is arithmetic. At n = 0 the output equals s exactly. `outValid` is low in all other cycles.
- R4: On each ramp tick, the attenuation moves exactly one unit toward the effective target. It holds when it already equals the target, and it never passes the target.
- R5: `rateSel` values 0, 1, 2 and 3 give a ramp tick every 1, 2, 4 and 8 strobes. A 3-bit counter counts strobes modulo 8 from reset. A strobe is a tick when the counter value, taken modulo the selected period, equals the period minus one.
- R6: The attenuation changes only on clock edges where `sampleValid` is high. Changes to `targetCode` or `rateSel` between strobes have no effect on the output until the next strobe.
- R7: While `muteReq` is high, the effective target is 724. A strobe taken while `muteReq` is high and the attenuation is already 724 yields `sampleOut` = 0.
- R8: `muteDone` is high in the clock after any cycle in which `muteReq` was high and the attenuation after that cycle's update is 724. It is low otherwise.
- R9: After `muteReq` falls, the attenuation ramps back toward 4 times the clamped code at the selected rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-clock strobe marking a new input sample |
| sampleIn | input | 24 | Signed input sample |
| targetCode | input | 8 | Attenuation code in 0.5 dB steps (0..181) |
| rateSel | input | 2 | Ramp pace: 1, 2, 4 or 8 strobes per 0.125 dB step |
| muteReq | input | 1 | Request a ramp to silence |
| sampleOut | output | 24 | Scaled, rounded and saturated sample |
| outValid | output | 1 | One-clock pulse when sampleOut is new |
| muteDone | output | 1 | Channel has reached full attenuation under mute |

## Verification
A wrong attenuation register shows up as a wrong output magnitude on the very next strobe, because every output sample is a fixed function of that register. A step of the wrong size or direction therefore becomes visible within one sample. A faulty strobe counter shifts the ramp schedule, so the output level departs from the bench model a few strobes later, and by the end of any long ramp the whole run of values is out of step. A fault in the mute path appears either as a non-zero sample once the ramp has reached 724, or as `muteDone` taking a value the model does not predict on the clock after the strobe.

// File: rtl/softVolPkg.sv
package softVolPkg;
  localparam int SAMPLE_W     = 24;
  localparam int GAIN_W       = 18;
  localparam int CODE_W       = 8;
  localparam int RATE_W       = 2;
  localparam int CODE_MAX     = 181;
  localparam int SUB_PER_CODE = 4;
  localparam int ATTEN_MAX    = CODE_MAX * SUB_PER_CODE;
  localparam int ATTEN_W      = $clog2(ATTEN_MAX + 1);
  localparam int SPAN_STEPS   = 48;
  localparam int CNT_W        = (1 << RATE_W) - 1;

  typedef struct packed {
    logic               load;
    logic               forceZero;
    logic [ATTEN_W-1:0] atten;
  } dpCtrl_t;
endpackage

// File: rtl/volRampCtrl.sv
module volRampCtrl
  import softVolPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [CODE_W-1:0] targetCode,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              muteReq,
  output dpCtrl_t           dpCtl,
  output logic              muteDone
);
  logic [ATTEN_W-1:0] curAtten, nextAtten, effTarget;
  logic [CODE_W-1:0]  codeClamp;
  logic [CNT_W-1:0]   strobeCnt, rateMask;
  logic               tick;

  always_comb begin
    codeClamp = (targetCode > CODE_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : targetCode;
    effTarget = muteReq ? ATTEN_W'(ATTEN_MAX)
                        : ATTEN_W'(codeClamp) * ATTEN_W'(SUB_PER_CODE);
    rateMask  = CNT_W'((1 << rateSel) - 1);
    tick      = sampleValid && ((strobeCnt & rateMask) == rateMask);
    nextAtten = curAtten;
    if (tick) begin
      if (curAtten < effTarget)      nextAtten = curAtten + 1'b1;
      else if (curAtten > effTarget) nextAtten = curAtten - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAtten  <= ATTEN_W'(ATTEN_MAX);
      strobeCnt <= '0;
      muteDone  <= 1'b0;
    end else begin
      curAtten <= nextAtten;
      if (sampleValid) strobeCnt <= strobeCnt + 1'b1;
      muteDone <= muteReq && (nextAtten == ATTEN_W'(ATTEN_MAX));
    end
  end

  always_comb begin
    dpCtl.load      = sampleValid;
    dpCtl.forceZero = muteReq && (curAtten == ATTEN_W'(ATTEN_MAX));
    dpCtl.atten     = curAtten;
  end
endmodule

// File: rtl/volGainPath.sv
module volGainPath
  import softVolPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtrl_t                    dpCtl,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic signed [SAMPLE_W-1:0] sampleOut,
  output logic                       outValid
);
  localparam int FRAC_W  = GAIN_W - 1;
  localparam int PROD_W  = SAMPLE_W + GAIN_W + 1;
  localparam int ACC_W   = PROD_W + 6;
  localparam int IDX_W   = $clog2(SPAN_STEPS);
  localparam int SHIFT_W = 6;
  localparam longint STEP_K = 64'd1058400094;

  function automatic logic [GAIN_W-1:0] fineGain(input int idx);
    longint g;
    g = 64'sd1 <<< 30;
    for (int i = 0; i < idx; i++) g = (g * STEP_K + (64'sd1 <<< 29)) >>> 30;
    return GAIN_W'((g + (64'sd1 <<< 12)) >>> 13);
  endfunction

  logic [GAIN_W-1:0] fineTab [SPAN_STEPS];
  for (genvar gi = 0; gi < SPAN_STEPS; gi++) begin : g_fine
    localparam logic [GAIN_W-1:0] FINE_V = fineGain(gi);
    assign fineTab[gi] = FINE_V;
  end

  logic [ATTEN_W-1:0]       spanIdx, fineIdxW;
  logic [IDX_W-1:0]         fineIdx;
  logic [SHIFT_W-1:0]       shiftAmt;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc, scaled;
  logic signed [SAMPLE_W-1:0] satVal;

  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((64'sd1 <<< (SAMPLE_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_LIM = -ACC_W'(64'sd1 <<< (SAMPLE_W - 1));

  always_comb begin
    spanIdx  = dpCtl.atten / ATTEN_W'(SPAN_STEPS);
    fineIdxW = dpCtl.atten % ATTEN_W'(SPAN_STEPS);
    fineIdx  = fineIdxW[IDX_W-1:0];
    shiftAmt = SHIFT_W'(FRAC_W) + SHIFT_W'(spanIdx);
    prod     = PROD_W'(sampleIn) * $signed({1'b0, fineTab[fineIdx]});
    acc      = ACC_W'(prod) + (ACC_W'(1) <<< (shiftAmt - 1'b1));
    scaled   = acc >>> shiftAmt;
    if (scaled > POS_LIM)      satVal = POS_LIM[SAMPLE_W-1:0];
    else if (scaled < NEG_LIM) satVal = NEG_LIM[SAMPLE_W-1:0];
    else                       satVal = scaled[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut <= '0;
      outValid  <= 1'b0;
    end else begin
      outValid <= dpCtl.load;
      if (dpCtl.load) sampleOut <= dpCtl.forceZero ? '0 : satVal;
    end
  end
endmodule

// File: rtl/softVolume.sv
module softVolume
  import softVolPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [CODE_W-1:0]   targetCode,
  input  logic [RATE_W-1:0]   rateSel,
  input  logic                muteReq,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                outValid,
  output logic                muteDone
);
  dpCtrl_t dpCtl;

  volRampCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .targetCode(targetCode),
    .rateSel(rateSel), .muteReq(muteReq), .dpCtl(dpCtl), .muteDone(muteDone)
  );

  volGainPath i_path (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .sampleIn(sampleIn),
    .sampleOut(sampleOut), .outValid(outValid)
  );
endmodule

// File: rtl/softVolumeChk.sv
module softVolumeChk
  import softVolPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                sampleValid,
  input logic [CODE_W-1:0]   targetCode,
  input logic                muteReq,
  input logic [ATTEN_W-1:0]  curAtten,
  input logic [SAMPLE_W-1:0] sampleOut,
  input logic                outValid,
  input logic                muteDone
);
  function automatic logic [ATTEN_W-1:0] goal(input logic m, input logic [CODE_W-1:0] c);
    if (m) return ATTEN_W'(ATTEN_MAX);
    return (c > CODE_W'(CODE_MAX)) ? ATTEN_W'(ATTEN_MAX) : ATTEN_W'(c) * ATTEN_W'(SUB_PER_CODE);
  endfunction

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rstN)
    curAtten <= ATTEN_W'(ATTEN_MAX));

  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(curAtten));

  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    (curAtten == $past(curAtten)) || (curAtten == $past(curAtten) + 1'b1)
    || (curAtten + 1'b1 == $past(curAtten)));

  a_r4_no_overshoot_up: assert property (@(posedge clk) disable iff (!rstN)
    (curAtten > $past(curAtten)) |-> ($past(curAtten) < $past(goal(muteReq, targetCode))));

  a_r4_no_overshoot_dn: assert property (@(posedge clk) disable iff (!rstN)
    (curAtten < $past(curAtten)) |-> ($past(curAtten) > $past(goal(muteReq, targetCode))));

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> outValid);

  a_r3_valid_only_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !outValid);

  a_r8_done_at_full: assert property (@(posedge clk) disable iff (!rstN)
    muteDone |-> (curAtten == ATTEN_W'(ATTEN_MAX)));

  a_r7_silent: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && muteReq && curAtten == ATTEN_W'(ATTEN_MAX)) |=> (sampleOut == '0));
endmodule

bind softVolume softVolumeChk u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .targetCode(targetCode),
  .muteReq(muteReq), .curAtten(dpCtl.atten), .sampleOut(sampleOut),
  .outValid(outValid), .muteDone(muteDone)
);

// File: tb/test_softVolume.sv
`timescale 1ns/1ps
module test_softVolume;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [23:0] sampleIn = '0;
  logic [7:0]  targetCode = '0;
  logic [1:0]  rateSel = '0;
  logic        muteReq = 1'b0;
  logic [23:0] sampleOut;
  logic        outValid, muteDone;

  softVolume i_softVolume (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .targetCode(targetCode), .rateSel(rateSel), .muteReq(muteReq),
    .sampleOut(sampleOut), .outValid(outValid), .muteDone(muteDone)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int attM;
  int cntM;

  typedef struct packed {
    logic [23:0] smp;
    logic [7:0]  code;
    logic [1:0]  rate;
    logic        mute;
    logic        alt;
    logic [11:0] reps;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{24'h100000, 8'd0,   2'd0, 1'b0, 1'b1, 12'd730},  // R4 R5: ramp 724 -> 0 at one strobe per step
    '{24'h200000, 8'd20,  2'd1, 1'b0, 1'b1, 12'd170},  // R5: two strobes per step, up to 80
    '{24'h0C3500, 8'd10,  2'd3, 1'b0, 1'b1, 12'd330},  // R5: eight strobes per step, down to 40
    '{24'h7FFFFF, 8'd200, 2'd0, 1'b0, 1'b0, 12'd700},  // R2: code above 181 acts as 181
    '{24'h400000, 8'd181, 2'd0, 1'b0, 1'b1, 12'd10},   // R4: hold at target
    '{24'h400000, 8'd0,   2'd2, 1'b0, 1'b1, 12'd100},  // R5: four strobes per step
    '{24'h400000, 8'd0,   2'd0, 1'b1, 1'b1, 12'd720},  // R7 R8: ramp to silence
    '{24'h7FFFFF, 8'd5,   2'd0, 1'b1, 1'b0, 12'd6},    // R7: stays silent while muted
    '{24'h123456, 8'd5,   2'd0, 1'b0, 1'b1, 12'd710},  // R9: ramp back to 20 on release
    '{24'h654321, 8'd0,   2'd0, 1'b0, 1'b1, 12'd30},   // R3: unity gain reached
    '{24'h7FFFFF, 8'd0,   2'd0, 1'b0, 1'b0, 12'd2},    // R3: positive full scale at 0 dB
    '{24'h800000, 8'd0,   2'd0, 1'b0, 1'b0, 12'd2}     // R3: negative full scale at 0 dB
  };

  function automatic int expOut(input logic [23:0] s, input int n, input logic m);
    longint p, e, sv;
    int g, k;
    if (m && n == 724) return 0;
    g  = $rtoi(131072.0 * (10.0 ** (-(n % 48) / 160.0)) + 0.5);
    k  = 17 + n / 48;
    sv = longint'($signed(s));
    p  = sv * g;
    e  = (p + (64'sd1 <<< (k - 1))) >>> k;
    if (e > 8388607) e = 8388607;
    if (e < -8388608) e = -8388608;
    return int'(e);
  endfunction

  function automatic int goalM(input logic m, input logic [7:0] c);
    if (m) return 724;
    return (c > 8'd181) ? 724 : 4 * int'(c);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [23:0] s);
    int e, a, tol, per, g;
    @(negedge clk);
    sampleIn = s;
    sampleValid = 1'b1;
    e   = expOut(s, attM, muteReq);
    tol = (attM == 0 || (muteReq && attM == 724)) ? 0
        : ((($signed(s) < 0) ? -int'($signed(s)) : int'($signed(s))) >>> (16 + attM / 48)) + 1;
    per = 1 << rateSel;
    g   = goalM(muteReq, targetCode);
    if ((cntM % per) == per - 1) begin
      if (attM < g) attM++;
      else if (attM > g) attM--;
    end
    cntM = (cntM + 1) % 8;
    @(negedge clk);
    sampleValid = 1'b0;
    a = int'($signed(sampleOut));
    check(outValid === 1'b1, "R3 outValid pulse", int'(outValid), 1);
    check(((a - e) <= tol) && ((e - a) <= tol), "R3/R4/R5 sample value", a, e);
    check(muteDone === (muteReq && attM == 724), "R8 muteDone", int'(muteDone),
          int'(muteReq && attM == 724));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    check(sampleOut == 24'd0, "R1 sampleOut at reset", int'(sampleOut), 0);
    check(outValid == 1'b0, "R1 outValid at reset", int'(outValid), 0);
    check(muteDone == 1'b0, "R1 muteDone at reset", int'(muteDone), 0);
    rstN = 1'b1;
    attM = 724;
    cntM = 0;
    @(negedge clk);
    check(outValid == 1'b0 && sampleOut == 24'd0, "R1 idle after reset", int'(outValid), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    // R1: first strobe after reset sees full attenuation
    targetCode = 8'd0;
    rateSel = 2'd0;
    strobe(24'h7FFFFF);

    foreach (VECS[vi]) begin
      targetCode = VECS[vi].code;
      rateSel    = VECS[vi].rate;
      muteReq    = VECS[vi].mute;
      for (int r = 0; r < int'(VECS[vi].reps); r++) begin
        if (VECS[vi].alt && r[0]) strobe(-VECS[vi].smp);
        else strobe(VECS[vi].smp);
      end
    end

    // R6: settings moved between strobes have no effect until the next strobe
    check(attM == 0, "R6 model at unity", attM, 0);
    targetCode = 8'd100;
    rateSel = 2'd0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R6 no output between strobes", int'(outValid), 0);
    end
    targetCode = 8'd0;
    strobe(24'h7FFFFF);
    check(int'($signed(sampleOut)) == 8388607, "R6 unity kept", int'($signed(sampleOut)), 8388607);

    // R9: release of mute mid-ramp turns the ramp around
    muteReq = 1'b1;
    for (int i = 0; i < 40; i++) strobe(24'h300000);
    muteReq = 1'b0;
    targetCode = 8'd2;
    for (int i = 0; i < 40; i++) strobe(24'h300000);
    check(attM == 8, "R9 model target", attM, 8);

    // R1: a second reset returns to full attenuation
    doReset();
    strobe(24'h7FFFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule